// File: doc/BRIEF.md
# Memory patrol scrubber

The patrol scrubber walks a configured window of a SECDED-protected memory, one word at a time and on a recurring schedule, so that soft errors picked up between ordinary accesses are removed before a second upset in the same word makes it unrecoverable. It shares the memory through a plain request/grant port with the normal traffic: a request is held until it is granted, and read data comes back later with a valid strobe.

Each word read is decoded. A clean word causes no further access. A word with one flipped bit is rewritten at the same address with the repaired codeword, and the finding is logged. A word with two flipped bits is never rewritten: its address is logged with a sticky flag and the walk moves on. A programmable gap separates consecutive reads, a pulse marks the end of every pass, and dropping the enable parks the block after the access in flight has completed, with its position kept.

Top module: `patrol_scrubber`

## Requirements
- R1: One pass reads every address from `cfg_first` up to and including `cfg_last`, in ascending order, one read each; the step after `cfg_last` goes back to `cfg_first`, and `pass_done` is high for exactly that one cycle.
- R2: Codeword layout: bit 0 is even parity over all other bits; the bits at power-of-two positions 1, 2, 4, 8, 16, 32 are check bits, the one at position 2^j giving even parity over every position whose index has bit j set; the 32 data bits fill the remaining positions from 3 upward, least significant first (39 bits in all).
- R3: A word that decodes clean causes no write and sets no flag.
- R4: A word with exactly one flipped bit (data, check or overall parity bit) is written back once to the same address with the corrected codeword; `ce_flag` becomes and stays 1 and `ce_addr` shows that address.
- R5: A word with two flipped bits is not written; `ue_flag` becomes and stays 1 and `ue_addr` shows its address (the most recent one by default).
- R6: With the grant high and read data one cycle after the grant, consecutive reads of clean words are granted 4 + `cfg_interval` cycles apart.
- R7: While `mem_gnt` is low a pending request stays asserted with address, direction and write data unchanged.
- R8: Dropping `cfg_en` lets the read in flight and any write-back it needs complete, then no further request is made; on re-enable the walk resumes at the next address.
- R9: After reset there is no request, both flags are 0 and `pass_done` is 0.
- R10: A one-cycle `stat_clr` clears both flags.
- R11: When the block leaves idle with its held address outside the window, the first read goes to `cfg_first`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Scrubbing enable |
| cfg_interval | input | IVL_W | Extra idle cycles between reads |
| cfg_first | input | ADDR_W | First address of the window |
| cfg_last | input | ADDR_W | Last address of the window |
| stat_clr | input | 1 | Clears both sticky flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W+7 | Corrected codeword for write-back |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W+7 | Read codeword |
| pass_done | output | 1 | One-cycle pulse at window wrap |
| ce_flag | output | 1 | Sticky correctable finding |
| ce_addr | output | ADDR_W | Address of latest correctable word |
| ue_flag | output | 1 | Sticky uncorrectable finding |
| ue_addr | output | ADDR_W | Address of logged uncorrectable word |

## Verification
A wrong address register shows within one pass as a read out of order, a skipped word or a missing `pass_done` at the window wrap. A faulty decode shows at the port within five cycles of the read grant as a write-back on a clean or doubly flipped word, or as a word left unrepaired in the memory model. A sequencer that drops a stalled request or ignores the enable shows as a request that vanishes while the grant is low, or as traffic continuing after the enable falls, within a few cycles.

// File: rtl/scrub_pkg.sv
`timescale 1ns/1ps
package scrub_pkg;

   typedef enum logic [2:0] {
      SC_IDLE,
      SC_WAIT,
      SC_RD_REQ,
      SC_RD_WAIT,
      SC_CHECK,
      SC_WR_REQ,
      SC_NEXT
   } scrub_state_e;

   // smallest number of Hamming check bits covering k data bits
   function automatic int chk_bits(input int k);
      for (int p = 1; p < 31; p++) begin
         if ((1 << p) >= k + p + 1) return p;
      end
      return 31;
   endfunction

   // data + Hamming check bits + overall parity bit
   function automatic int cw_width(input int k);
      return k + chk_bits(k) + 1;
   endfunction

endpackage

// File: rtl/scrub_secded_dec.sv
`timescale 1ns/1ps
module scrub_secded_dec #(
   parameter int CW_W  = 39,
   parameter int SYN_W = 6
) (
   input  logic [CW_W-1:0] cw_i,
   output logic            ce_o,
   output logic            ue_o,
   output logic [CW_W-1:0] fix_o
);

   if ((1 << SYN_W) < CW_W) begin : g_bad_syn
      $error("scrub_secded_dec: SYN_W too small for CW_W");
   end

   logic [SYN_W-1:0] syn;
   logic             par;
   logic             in_rng;

   // syndrome: XOR of the indices of all set bits above position 0
   always_comb begin
      syn = '0;
      for (int i = 1; i < CW_W; i++) begin
         if (cw_i[i]) syn = syn ^ SYN_W'(i);
      end
   end

   assign par    = ^cw_i;
   assign in_rng = (32'(syn) < CW_W);
   assign ce_o   = par && in_rng;
   assign ue_o   = (!par && (syn != '0)) || (par && !in_rng);

   for (genvar g = 0; g < CW_W; g++) begin : g_fix
      assign fix_o[g] = cw_i[g] ^ (ce_o && (syn == SYN_W'(g)));
   end

endmodule

// File: rtl/scrub_pace.sv
`timescale 1ns/1ps
module scrub_pace #(
   parameter int IVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [IVL_W-1:0] val_i,
   input  logic             dec_i,
   output logic             zero_o
);

   if (IVL_W < 1) begin : g_bad_w
      $error("scrub_pace: IVL_W must be at least 1");
   end

   logic [IVL_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= val_i;
      else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/scrub_addr.sv
`timescale 1ns/1ps
module scrub_addr #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              align_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] first_i,
   input  logic [ADDR_W-1:0] last_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wrap_o
);

   if (ADDR_W < 1) begin : g_bad_w
      $error("scrub_addr: ADDR_W must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              outside;

   assign outside = (addr_q < first_i) || (addr_q > last_i);
   assign wrap_o  = (addr_q >= last_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   addr_q <= '0;
      else if (align_i && outside)  addr_q <= first_i;
      else if (step_i)              addr_q <= wrap_o ? first_i : addr_q + 1'b1;
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/patrol_scrubber.sv
`timescale 1ns/1ps
module patrol_scrubber #(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 6,
   parameter int IVL_W         = 8,
   parameter bit UE_KEEP_FIRST = 1'b0
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         cfg_en,
   input  logic [IVL_W-1:0]                             cfg_interval,
   input  logic [ADDR_W-1:0]                            cfg_first,
   input  logic [ADDR_W-1:0]                            cfg_last,
   input  logic                                         stat_clr,
   output logic                                         mem_req,
   output logic                                         mem_we,
   output logic [ADDR_W-1:0]                            mem_addr,
   output logic [scrub_pkg::cw_width(DATA_W)-1:0]       mem_wdata,
   input  logic                                         mem_gnt,
   input  logic                                         mem_rvalid,
   input  logic [scrub_pkg::cw_width(DATA_W)-1:0]       mem_rdata,
   output logic                                         pass_done,
   output logic                                         ce_flag,
   output logic [ADDR_W-1:0]                            ce_addr,
   output logic                                         ue_flag,
   output logic [ADDR_W-1:0]                            ue_addr
);
   import scrub_pkg::*;

   localparam int SYN_W = chk_bits(DATA_W);
   localparam int CW_W  = cw_width(DATA_W);

   if (DATA_W < 4) begin : g_bad_data
      $error("patrol_scrubber: DATA_W must be at least 4");
   end

   scrub_state_e      state_q, state_d;
   logic [CW_W-1:0]   rd_q;
   logic [CW_W-1:0]   fix;
   logic              dec_ce, dec_ue;
   logic              pace_zero, pace_load;
   logic              ivl_zero;
   logic              addr_wrap;
   logic [ADDR_W-1:0] cur_addr;
   logic              leaving_idle, in_check;

   assign ivl_zero     = (cfg_interval == '0);
   assign leaving_idle = (state_q == SC_IDLE) && cfg_en;
   assign in_check     = (state_q == SC_CHECK);
   assign pace_load    = cfg_en && ((state_q == SC_IDLE) || (state_q == SC_NEXT)) && !ivl_zero;

   scrub_pace #(.IVL_W(IVL_W)) u_pace (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (pace_load),
      .val_i  (cfg_interval - 1'b1),
      .dec_i  (state_q == SC_WAIT),
      .zero_o (pace_zero)
   );

   scrub_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .align_i (leaving_idle),
      .step_i  (state_q == SC_NEXT),
      .first_i (cfg_first),
      .last_i  (cfg_last),
      .addr_o  (cur_addr),
      .wrap_o  (addr_wrap)
   );

   scrub_secded_dec #(.CW_W(CW_W), .SYN_W(SYN_W)) u_dec (
      .cw_i  (rd_q),
      .ce_o  (dec_ce),
      .ue_o  (dec_ue),
      .fix_o (fix)
   );

   // sequencer
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SC_IDLE:    if (cfg_en) state_d = ivl_zero ? SC_RD_REQ : SC_WAIT;
         SC_WAIT:    if (!cfg_en) state_d = SC_IDLE;
                     else if (pace_zero) state_d = SC_RD_REQ;
         SC_RD_REQ:  if (mem_gnt) state_d = SC_RD_WAIT;
         SC_RD_WAIT: if (mem_rvalid) state_d = SC_CHECK;
         SC_CHECK:   state_d = dec_ce ? SC_WR_REQ : SC_NEXT;
         SC_WR_REQ:  if (mem_gnt) state_d = SC_NEXT;
         SC_NEXT:    if (!cfg_en) state_d = SC_IDLE;
                     else state_d = ivl_zero ? SC_RD_REQ : SC_WAIT;
         default:    state_d = SC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SC_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     rd_q <= '0;
      else if ((state_q == SC_RD_WAIT) && mem_rvalid) rd_q <= mem_rdata;
   end

   // memory port
   assign mem_req   = (state_q == SC_RD_REQ) || (state_q == SC_WR_REQ);
   assign mem_we    = (state_q == SC_WR_REQ);
   assign mem_addr  = cur_addr;
   assign mem_wdata = fix;
   assign pass_done = (state_q == SC_NEXT) && addr_wrap;

   // correctable log
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_flag <= 1'b0;
         ce_addr <= '0;
      end else if (in_check && dec_ce) begin
         ce_flag <= 1'b1;
         ce_addr <= cur_addr;
      end else if (stat_clr) begin
         ce_flag <= 1'b0;
      end
   end

   // uncorrectable log
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ue_flag <= 1'b0;
      else if (in_check && dec_ue) ue_flag <= 1'b1;
      else if (stat_clr)           ue_flag <= 1'b0;
   end

   if (UE_KEEP_FIRST) begin : g_ue_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ue_addr <= '0;
         else if (in_check && dec_ue && (!ue_flag || stat_clr)) ue_addr <= cur_addr;
      end
   end else begin : g_ue_last
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  ue_addr <= '0;
         else if (in_check && dec_ue) ue_addr <= cur_addr;
      end
   end

endmodule

// File: rtl/scrub_chk.sv
`timescale 1ns/1ps
module scrub_chk #(
   parameter int ADDR_W = 6,
   parameter int CW_W   = 39
) (
   input logic                      clk,
   input logic                      rst_n,
   input scrub_pkg::scrub_state_e   state_q,
   input logic                      mem_req,
   input logic                      mem_we,
   input logic                      mem_gnt,
   input logic [ADDR_W-1:0]         mem_addr,
   input logic [CW_W-1:0]           mem_wdata,
   input logic [ADDR_W-1:0]         cfg_first,
   input logic                      pass_done,
   input logic                      ce_flag,
   input logic                      ue_flag,
   input logic                      stat_clr,
   input logic                      dec_ce,
   input logic                      dec_ue
);
   import scrub_pkg::*;

   // R7: a stalled request stays up and unchanged
   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R4: a write is only issued for a correctable word
   p_wr_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> dec_ce);

   // R5: never write while the held word is uncorrectable
   p_no_wr_on_ue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !dec_ue);

   // R1: the wrap pulse lasts one cycle
   p_pass_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);

   // R1: after the wrap the address is the window start
   p_pass_to_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> mem_addr == cfg_first);

   // R5: uncorrectable flag is sticky
   p_ue_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ue_flag && !stat_clr |=> ue_flag);

   // R4: correctable flag is sticky
   p_ce_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ce_flag && !stat_clr |=> ce_flag);

   // R8: no request while parked
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == SC_IDLE |-> !mem_req);

   // R10: a clear outside a check leaves both flags low
   p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr && state_q != SC_CHECK |=> !ce_flag && !ue_flag);

endmodule

bind patrol_scrubber scrub_chk #(.ADDR_W(ADDR_W), .CW_W(CW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .state_q   (state_q),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_gnt   (mem_gnt),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .cfg_first (cfg_first),
   .pass_done (pass_done),
   .ce_flag   (ce_flag),
   .ue_flag   (ue_flag),
   .stat_clr  (stat_clr),
   .dec_ce    (dec_ce),
   .dec_ue    (dec_ue)
);

// File: tb/patrol_scrubber_tb.sv
`timescale 1ns/1ps
module patrol_scrubber_tb;

   localparam int AW = 6;
   localparam int IW = 8;
   localparam int CW = 39;   // 32 data + 6 check + 1 overall parity
   localparam int NV = 8;

   // {data, flip_a, flip_b, kind}; flip 255 = none; kind 0 clean, 1 single, 2 double
   localparam logic [49:0] VEC [0:NV-1] = '{
      {32'h0000_0038, 8'd255, 8'd255, 2'd0},
      {32'hDEAD_BEEF, 8'd5,   8'd255, 2'd1},
      {32'h1234_5678, 8'd0,   8'd255, 2'd1},
      {32'hFFFF_0000, 8'd3,   8'd17,  2'd2},
      {32'hA5A5_5A5A, 8'd16,  8'd255, 2'd1},
      {32'h0000_0001, 8'd255, 8'd255, 2'd0},
      {32'h8000_0000, 8'd0,   8'd9,   2'd2},
      {32'h0F0F_0F0F, 8'd38,  8'd255, 2'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0;
   logic [IW-1:0] cfg_interval = '0;
   logic [AW-1:0] cfg_first = '0;
   logic [AW-1:0] cfg_last = '0;
   logic          stat_clr = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [CW-1:0] mem_wdata;
   logic          mem_gnt = 1'b1;
   logic          mem_rvalid = 1'b0;
   logic [CW-1:0] mem_rdata = '0;
   logic          pass_done, ce_flag, ue_flag;
   logic [AW-1:0] ce_addr, ue_addr;

   always #2.5 clk = ~clk;

   patrol_scrubber u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_interval(cfg_interval),
      .cfg_first(cfg_first), .cfg_last(cfg_last), .stat_clr(stat_clr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .pass_done(pass_done), .ce_flag(ce_flag), .ce_addr(ce_addr),
      .ue_flag(ue_flag), .ue_addr(ue_addr)
   );

   // memory model with access log
   logic [CW-1:0] mem [0:63];
   int            wr_hits [0:63];
   logic [AW-1:0] rd_log [0:127];
   int            rd_cyc [0:127];
   int            rd_n = 0;
   int            cyc = 0;
   logic          ld_en = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [CW-1:0] ld_data = '0;
   logic          log_clr = 1'b0;

   always @(posedge clk) begin
      cyc        <= cyc + 1;
      mem_rvalid <= 1'b0;
      if (ld_en) mem[ld_addr] <= ld_data;
      if (log_clr) begin
         rd_n <= 0;
         for (int i = 0; i < 64; i++) wr_hits[i] <= 0;
      end else if (mem_req && mem_gnt) begin
         if (mem_we) begin
            mem[mem_addr]     <= mem_wdata;
            wr_hits[mem_addr] <= wr_hits[mem_addr] + 1;
         end else begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr];
            if (rd_n < 128) begin
               rd_log[rd_n] <= mem_addr;
               rd_cyc[rd_n] <= cyc;
            end
            rd_n <= rd_n + 1;
         end
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // encoder written from the R2 layout
   function automatic logic [CW-1:0] enc(input logic [31:0] d);
      logic [CW-1:0] c;
      logic          x;
      int            k;
      c = '0;
      k = 0;
      for (int pos = 1; pos < CW; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            c[pos] = d[k];
            k++;
         end
      end
      for (int j = 0; j < 6; j++) begin
         x = 1'b0;
         for (int pos = 1; pos < CW; pos++)
            if ((((pos >> j) & 1) == 1) && (pos != (1 << j))) x = x ^ c[pos];
         c[1 << j] = x;
      end
      c[0] = ^c[CW-1:1];
      return c;
   endfunction

   function automatic logic [CW-1:0] corrupt(input logic [CW-1:0] c, input int fa, input int fb);
      logic [CW-1:0] r;
      r = c;
      if (fa < CW) r[fa] = ~r[fa];
      if (fb < CW) r[fb] = ~r[fb];
      return r;
   endfunction

   task automatic load(input int a, input logic [CW-1:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(a); ld_data = v;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic clear_log();
      @(negedge clk);
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
   endtask

   task automatic wait_reads(input int n);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (rd_n >= n) break;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   initial begin
      logic [AW-1:0] held;
      logic          held_ok;
      logic          seen_pass;

      // ---- R9: reset state
      idle(4);
      rst_n = 1'b1;
      idle(2);
      chk("R9 mem_req after reset", 64'(mem_req), 64'd0);
      chk("R9 ce_flag after reset", 64'(ce_flag), 64'd0);
      chk("R9 ue_flag after reset", 64'(ue_flag), 64'd0);
      chk("R9 pass_done after reset", 64'(pass_done), 64'd0);
      idle(8);
      chk("R9 no request while disabled", 64'(mem_req), 64'd0);

      // ---- table pass: R1 R3 R4 R5 R6 R11 (R2 via encoder)
      for (int i = 0; i < NV; i++)
         load(4 + i, corrupt(enc(VEC[i][49:18]), int'(VEC[i][17:10]), int'(VEC[i][9:2])));
      cfg_first = 6'd4; cfg_last = 6'd11; cfg_interval = '0; mem_gnt = 1'b1;
      clear_log();
      cfg_en = 1'b1;
      seen_pass = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (pass_done) begin
            seen_pass = 1'b1;
            cfg_en = 1'b0;
            break;
         end
      end
      chk("R1 pass_done seen", 64'(seen_pass), 64'd1);
      idle(20);
      chk("R1 reads in one pass", 64'(rd_n), 64'd8);
      chk("R11 first read at window start", 64'(rd_log[0]), 64'd4);
      for (int i = 0; i < NV; i++) begin
         chk($sformatf("R1 read order slot %0d", i), 64'(rd_log[i]), 64'(4 + i));
         case (int'(VEC[i][1:0]))
            0: begin
               chk($sformatf("R3 no write addr %0d", 4 + i), 64'(wr_hits[4 + i]), 64'd0);
               chk($sformatf("R2 clean word kept addr %0d", 4 + i), 64'(mem[4 + i]), 64'(enc(VEC[i][49:18])));
            end
            1: begin
               chk($sformatf("R4 one write addr %0d", 4 + i), 64'(wr_hits[4 + i]), 64'd1);
               chk($sformatf("R4 repaired addr %0d", 4 + i), 64'(mem[4 + i]), 64'(enc(VEC[i][49:18])));
            end
            default: begin
               chk($sformatf("R5 no write addr %0d", 4 + i), 64'(wr_hits[4 + i]), 64'd0);
               chk($sformatf("R5 left as read addr %0d", 4 + i), 64'(mem[4 + i]),
                   64'(corrupt(enc(VEC[i][49:18]), int'(VEC[i][17:10]), int'(VEC[i][9:2]))));
            end
         endcase
      end
      chk("R6 spacing clean slot0->1 (I=0)", 64'(rd_cyc[1] - rd_cyc[0]), 64'd4);
      chk("R6 spacing clean slot5->6 (I=0)", 64'(rd_cyc[6] - rd_cyc[5]), 64'd4);
      chk("R4 ce_flag", 64'(ce_flag), 64'd1);
      chk("R4 ce_addr latest", 64'(ce_addr), 64'd11);
      chk("R5 ue_flag", 64'(ue_flag), 64'd1);
      chk("R5 ue_addr latest", 64'(ue_addr), 64'd10);
      chk("R8 parked after disable", 64'(mem_req), 64'd0);

      // wrap: resumes at window start
      clear_log();
      cfg_en = 1'b1;
      wait_reads(1);
      cfg_en = 1'b0;
      idle(10);
      chk("R1 read after wrap at window start", 64'(rd_log[0]), 64'd4);
      chk("R5 ue_flag still set", 64'(ue_flag), 64'd1);

      // ---- R10 clear
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0;
      chk("R10 ce_flag cleared", 64'(ce_flag), 64'd0);
      chk("R10 ue_flag cleared", 64'(ue_flag), 64'd0);

      // ---- R6 interval 5 on clean words, R11 realign (held address 5 outside 0..3)
      for (int i = 0; i < 4; i++) load(i, enc(32'h1111_0000 + 32'(i)));
      cfg_first = 6'd0; cfg_last = 6'd3; cfg_interval = 8'd5;
      clear_log();
      cfg_en = 1'b1;
      wait_reads(3);
      cfg_en = 1'b0;
      idle(30);
      chk("R11 realigned to window start", 64'(rd_log[0]), 64'd0);
      chk("R6 spacing I=5 first", 64'(rd_cyc[1] - rd_cyc[0]), 64'd9);
      chk("R6 spacing I=5 second", 64'(rd_cyc[2] - rd_cyc[1]), 64'd9);
      chk("R3 clean words no write", 64'(wr_hits[0] + wr_hits[1] + wr_hits[2]), 64'd0);
      chk("R3 clean words set no flag", 64'({ce_flag, ue_flag}), 64'd0);

      // ---- R7 read stall, R8 resume at next address (3)
      cfg_interval = '0;
      clear_log();
      mem_gnt = 1'b0;
      cfg_en = 1'b1;
      idle(3);
      held = mem_addr;
      held_ok = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!(mem_req && !mem_we && mem_addr == held)) held_ok = 1'b0;
      end
      chk("R7 read request held while grant low", 64'(held_ok), 64'd1);
      chk("R7 nothing granted during stall", 64'(rd_n), 64'd0);
      mem_gnt = 1'b1;
      wait_reads(1);
      cfg_en = 1'b0;
      idle(10);
      chk("R8 resumed at next address", 64'(rd_log[0]), 64'd3);
      chk("R7 granted address equals held one", 64'(rd_log[0]), 64'(held));

      // ---- R8 disable during read-modify-write with a stalled write
      load(20, corrupt(enc(32'h5555_AAAA), 7, 255));
      load(21, enc(32'h0000_0021));
      load(22, enc(32'h0000_0022));
      cfg_first = 6'd20; cfg_last = 6'd22;
      clear_log();
      cfg_en = 1'b1;
      wait_reads(1);
      cfg_en = 1'b0;
      mem_gnt = 1'b0;
      idle(5);
      chk("R8 write-back still requested", 64'({mem_req, mem_we}), 64'h3);
      chk("R7 write address held", 64'(mem_addr), 64'd20);
      mem_gnt = 1'b1;
      idle(10);
      chk("R8 write-back completed", 64'(wr_hits[20]), 64'd1);
      chk("R8 repaired word stored", 64'(mem[20]), 64'(enc(32'h5555_AAAA)));
      chk("R8 no read after disable", 64'(rd_n), 64'd1);
      chk("R8 request low when parked", 64'(mem_req), 64'd0);
      chk("R4 ce_addr after repair", 64'(ce_addr), 64'd20);
      clear_log();
      cfg_en = 1'b1;
      wait_reads(1);
      cfg_en = 1'b0;
      idle(10);
      chk("R8 address kept across disable", 64'(rd_log[0]), 64'd21);

      summary();
      $finish;
   end

endmodule